// File: doc/BRIEF.md
# Nibble-Select Pixel Input Pipeline

This block is the pixel input stage of a video palette front end. Every pixel clock it latches the full 8-bit pixel bus while the line is active. It then passes the byte on through a short register pipe to a read-mask stage, which produces the palette index. In the double-buffered nibble mode, each input byte holds one 4-bit pixel for each of two frame buffers. A buffer-select flag is sampled while blank is high, between lines. For the whole of the next active line, the sampled flag chooses which half of every byte is forwarded. The chosen half is zero-extended to 8 bits.

Software enables the mode with two control bits: nibble mode and split shift-register transfer. These two settings exclude each other. When both are set, the block raises an error output, and nibble handling takes precedence in the datapath. When neither bit is set, the flag input is ignored and whole bytes pass through. A valid output travels with the data through every stage, so index and valid leave the block in the same cycle.

Top module: `nsp_pixel_pipe`

## Requirements
- R1: In nibble mode a sampled flag of 0 forwards pixel bits [3:0], and a sampled flag of 1 forwards pixel bits [7:4], placed in the low 4 bits of the index.
- R2: In nibble mode the upper 4 bits of the pipe value, and so of the index, are always 0.
- R3: The flag is sampled on every clock edge where blank is high and a mode bit is set; it holds its value through the whole active line, whatever the flag input does then.
- R4: With both mode bits 0 the flag input is ignored (the sampled flag keeps its value), and the full 8-bit pixel passes unchanged.
- R5: The error output is 1 one cycle after both mode bits are 1, and 0 one cycle after they are not both 1.
- R6: The index equals the 8-bit pipe value ANDed bitwise with the read mask.
- R7: A pixel present on the bus at a clock edge with blank low appears at the output, with valid high, three clock edges later. Valid is low for pixels offered while blank is high, so the first pixel after blank falls and the last one before blank rises are both kept.
- R8: Reset clears the sampled flag and all pipe registers. While valid is low the index reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| blank_i | input | 1 | High during blanking; no pixel capture |
| bufsel_i | input | 1 | Buffer-select flag, sampled during blanking |
| pix_i | input | 8 | Pixel data bus |
| mode_nibble_i | input | 1 | Nibble-mode enable |
| mode_split_i | input | 1 | Split shift-register transfer enable |
| rd_mask_i | input | 8 | Read mask applied to the index |
| idx_o | output | 8 | Palette index |
| idx_vld_o | output | 1 | Index valid |
| mode_err_o | output | 1 | Both mode bits set |

## Verification
The assertions assume that reset lasts at least three cycles, so each delayed look at blank lands on a driven value. They also assume the mode bits are stable across the cycle in which a latched pixel moves into the pipe register. The stimulus changes the mode bits and the read mask only during blanking, or on the same edge as blank falls. It then leaves enough blank cycles for the pipe to drain before the next change.

// File: rtl/nsp_pkg.sv
package nsp_pkg;

    localparam int PIX_W = 8;
    localparam int NIB_W = PIX_W / 2;

    typedef struct packed {
        logic             vld;
        logic [PIX_W-1:0] data;
    } pix_beat_t;

    typedef enum logic [1:0] {
        MODE_FULL   = 2'b00,
        MODE_SPLIT  = 2'b01,
        MODE_NIBBLE = 2'b10,
        MODE_CLASH  = 2'b11
    } in_mode_e;

    // zero-extended half of a pixel byte
    function automatic logic [PIX_W-1:0] pick_nibble(input logic [PIX_W-1:0] b,
                                                     input logic hi);
        logic [PIX_W-1:0] r;
        r = '0;
        r[NIB_W-1:0] = hi ? b[PIX_W-1:NIB_W] : b[NIB_W-1:0];
        return r;
    endfunction

    function automatic logic nibble_active(input in_mode_e m);
        return (m == MODE_NIBBLE) || (m == MODE_CLASH);
    endfunction

    function automatic logic flag_used(input in_mode_e m);
        return m != MODE_FULL;
    endfunction

endpackage

// File: rtl/nsp_flag_sampler.sv
module nsp_flag_sampler (
    input  logic clk,
    input  logic rst,
    input  logic blank_i,
    input  logic flag_i,
    input  logic enable_i,
    output logic flag_o
);
    always_ff @(posedge clk) begin
        if (rst) begin
            flag_o <= 1'b0;
        end else if (blank_i && enable_i) begin
            flag_o <= flag_i;
        end
    end
endmodule

// File: rtl/nsp_input_latch.sv
module nsp_input_latch
    import nsp_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             blank_i,
    input  logic [PIX_W-1:0] pix_i,
    output pix_beat_t        beat_o
);
    always_ff @(posedge clk) begin
        if (rst) begin
            beat_o <= '0;
        end else begin
            beat_o.vld <= !blank_i;
            if (!blank_i) begin
                beat_o.data <= pix_i;
            end
        end
    end
endmodule

// File: rtl/nsp_nibble_stage.sv
module nsp_nibble_stage
    import nsp_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  pix_beat_t beat_i,
    input  in_mode_e  mode_i,
    input  logic      sel_hi_i,
    output pix_beat_t beat_o
);
    pix_beat_t nxt;

    always_comb begin
        nxt.vld  = beat_i.vld;
        nxt.data = nibble_active(mode_i) ? pick_nibble(beat_i.data, sel_hi_i)
                                         : beat_i.data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            beat_o <= '0;
        end else begin
            beat_o <= nxt;
        end
    end
endmodule

// File: rtl/nsp_mask_stage.sv
module nsp_mask_stage
    import nsp_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  pix_beat_t        beat_i,
    input  logic [PIX_W-1:0] mask_i,
    output logic [PIX_W-1:0] idx_o,
    output logic             vld_o
);
    always_ff @(posedge clk) begin
        if (rst) begin
            idx_o <= '0;
            vld_o <= 1'b0;
        end else begin
            vld_o <= beat_i.vld;
            idx_o <= beat_i.vld ? (beat_i.data & mask_i) : '0;
        end
    end
endmodule

// File: rtl/nsp_pixel_pipe.sv
module nsp_pixel_pipe
    import nsp_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             blank_i,
    input  logic             bufsel_i,
    input  logic [PIX_W-1:0] pix_i,
    input  logic             mode_nibble_i,
    input  logic             mode_split_i,
    input  logic [PIX_W-1:0] rd_mask_i,
    output logic [PIX_W-1:0] idx_o,
    output logic             idx_vld_o,
    output logic             mode_err_o
);
    in_mode_e  mode;
    logic      flag_q;
    pix_beat_t lat_beat;
    pix_beat_t nib_beat;

    assign mode = in_mode_e'({mode_nibble_i, mode_split_i});

    nsp_flag_sampler u_flag (
        .clk      (clk),
        .rst      (rst),
        .blank_i  (blank_i),
        .flag_i   (bufsel_i),
        .enable_i (flag_used(mode)),
        .flag_o   (flag_q)
    );

    nsp_input_latch u_latch (
        .clk     (clk),
        .rst     (rst),
        .blank_i (blank_i),
        .pix_i   (pix_i),
        .beat_o  (lat_beat)
    );

    nsp_nibble_stage u_nib (
        .clk      (clk),
        .rst      (rst),
        .beat_i   (lat_beat),
        .mode_i   (mode),
        .sel_hi_i (flag_q),
        .beat_o   (nib_beat)
    );

    nsp_mask_stage u_mask (
        .clk    (clk),
        .rst    (rst),
        .beat_i (nib_beat),
        .mask_i (rd_mask_i),
        .idx_o  (idx_o),
        .vld_o  (idx_vld_o)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_err_o <= 1'b0;
        end else begin
            mode_err_o <= (mode == MODE_CLASH);
        end
    end
endmodule

// File: rtl/nsp_checker.sv
module nsp_checker (
    input logic       clk,
    input logic       rst,
    input logic       blank_i,
    input logic       mode_nibble_i,
    input logic       mode_split_i,
    input logic [7:0] rd_mask_i,
    input logic       flag_q,
    input logic       lat_vld,
    input logic [3:0] nib_hi,
    input logic [7:0] idx_o,
    input logic       idx_vld_o,
    input logic       mode_err_o
);
    // R2
    a_r2_high_zero: assert property (@(posedge clk) disable iff (rst)
        (lat_vld && mode_nibble_i) |=> (nib_hi == 4'h0));

    // R3
    a_r3_flag_hold: assert property (@(posedge clk) disable iff (rst)
        !blank_i |=> $stable(flag_q));

    // R4
    a_r4_flag_ignored: assert property (@(posedge clk) disable iff (rst)
        (!mode_nibble_i && !mode_split_i) |=> $stable(flag_q));

    // R5
    a_r5_err_set: assert property (@(posedge clk) disable iff (rst)
        (mode_nibble_i && mode_split_i) |=> mode_err_o);

    a_r5_err_clear: assert property (@(posedge clk) disable iff (rst)
        !(mode_nibble_i && mode_split_i) |=> !mode_err_o);

    // R6
    a_r6_mask_bits: assert property (@(posedge clk) disable iff (rst)
        idx_vld_o |-> ((idx_o & ~$past(rd_mask_i)) == 8'h00));

    // R7
    a_r7_vld_from_blank: assert property (@(posedge clk) disable iff (rst)
        idx_vld_o |-> !$past(blank_i, 3));

    // R8
    a_r8_idle_zero: assert property (@(posedge clk) disable iff (rst)
        !idx_vld_o |-> (idx_o == 8'h00));
endmodule

bind nsp_pixel_pipe nsp_checker u_chk (
    .clk           (clk),
    .rst           (rst),
    .blank_i       (blank_i),
    .mode_nibble_i (mode_nibble_i),
    .mode_split_i  (mode_split_i),
    .rd_mask_i     (rd_mask_i),
    .flag_q        (flag_q),
    .lat_vld       (lat_beat.vld),
    .nib_hi        (nib_beat.data[7:4]),
    .idx_o         (idx_o),
    .idx_vld_o     (idx_vld_o),
    .mode_err_o    (mode_err_o)
);

// File: tb/nsp_pixel_pipe_tb.sv
`timescale 1ns/1ps
module nsp_pixel_pipe_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       blank_i = 1'b1;
    logic       bufsel_i = 1'b0;
    logic [7:0] pix_i = 8'h00;
    logic       mode_nibble_i = 1'b0;
    logic       mode_split_i = 1'b0;
    logic [7:0] rd_mask_i = 8'hFF;
    logic [7:0] idx_o;
    logic       idx_vld_o;
    logic       mode_err_o;

    int checks = 0;
    int errors = 0;

    // bench model: sampled flag and a three-deep expected pipe
    logic       mflag = 1'b0;
    logic       ev [0:2];
    logic [7:0] ed [0:2];

    always #2 clk = ~clk;

    nsp_pixel_pipe u_dut (
        .clk           (clk),
        .rst           (rst),
        .blank_i       (blank_i),
        .bufsel_i      (bufsel_i),
        .pix_i         (pix_i),
        .mode_nibble_i (mode_nibble_i),
        .mode_split_i  (mode_split_i),
        .rd_mask_i     (rd_mask_i),
        .idx_o         (idx_o),
        .idx_vld_o     (idx_vld_o),
        .mode_err_o    (mode_err_o)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    // one cycle: compare outputs at the negedge, then drive the next inputs
    task automatic step(input string req, input logic blank, input logic flag,
                        input logic [7:0] pix, input logic nib, input logic split,
                        input logic [7:0] mask);
        logic [7:0] v;
        @(negedge clk);
        check({req, " R7 valid"}, {7'd0, idx_vld_o}, {7'd0, ev[2]});
        check({req, " data"}, idx_o, ed[2]);
        blank_i = blank; bufsel_i = flag; pix_i = pix;
        mode_nibble_i = nib; mode_split_i = split; rd_mask_i = mask;
        if (blank && (nib || split)) mflag = flag;
        v = 8'h00;
        if (!blank) begin
            if (nib) v = mflag ? {4'h0, pix[7:4]} : {4'h0, pix[3:0]};
            else     v = pix;
            v = v & mask;
        end
        ev[2] = ev[1]; ed[2] = ed[1];
        ev[1] = ev[0]; ed[1] = ed[0];
        ev[0] = !blank; ed[0] = v;
    endtask

    task automatic run_line(input string req, input logic nib, input logic split,
                            input logic flag, input logic [7:0] mask,
                            input int npix, input logic [7:0] base);
        for (int i = 0; i < 4; i++) step(req, 1'b1, flag, 8'h00, nib, split, mask);
        // flag toggles during the active line; the sampled value must hold (R3)
        for (int i = 0; i < npix; i++)
            step(req, 1'b0, (i % 2 == 0) ? ~flag : flag, base + 8'(i * 37), nib, split, mask);
        for (int i = 0; i < 4; i++) step(req, 1'b1, flag, 8'h00, nib, split, mask);
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (4) @(posedge clk);
        @(negedge clk);
        check("R8 reset idx", idx_o, 8'h00);
        check("R8 reset vld", {7'd0, idx_vld_o}, 8'h00);
        check("R8 reset err", {7'd0, mode_err_o}, 8'h00);
        rst = 1'b0;
        mflag = 1'b0;
        for (int i = 0; i < 3; i++) begin ev[i] = 1'b0; ed[i] = 8'h00; end
    endtask

    task automatic t_full_pass();
        run_line("R4 full pass", 1'b0, 1'b0, 1'b1, 8'hFF, 9, 8'h5A);
    endtask

    task automatic t_nibble_low();
        run_line("R1 nibble low", 1'b1, 1'b0, 1'b0, 8'hFF, 10, 8'hC3);
    endtask

    task automatic t_nibble_high();
        run_line("R2 nibble high", 1'b1, 1'b0, 1'b1, 8'hFF, 10, 8'h3C);
    endtask

    task automatic t_mask();
        run_line("R6 mask full", 1'b0, 1'b1, 1'b0, 8'h3C, 8, 8'h11);
        run_line("R6 mask nibble", 1'b1, 1'b0, 1'b1, 8'hA5, 8, 8'hE7);
    endtask

    task automatic t_ignore();
        // set sampled flag to 0 in nibble mode
        run_line("R4 setup", 1'b1, 1'b0, 1'b0, 8'hFF, 2, 8'h96);
        // blanking with both mode bits clear: flag=1 must not be sampled
        for (int i = 0; i < 4; i++) step("R4 ignore", 1'b1, 1'b1, 8'h00, 1'b0, 1'b0, 8'hFF);
        // nibble mode switched on as blank falls: low half still selected
        for (int i = 0; i < 6; i++)
            step("R4 ignore", 1'b0, 1'b1, 8'hB0 + 8'(i * 17), 1'b1, 1'b0, 8'hFF);
        for (int i = 0; i < 4; i++) step("R4 ignore", 1'b1, 1'b0, 8'h00, 1'b1, 1'b0, 8'hFF);
    endtask

    task automatic t_short_lines();
        // one-pixel and two-pixel lines check first/last pixel capture
        run_line("R7 single", 1'b1, 1'b0, 1'b1, 8'hFF, 1, 8'h9E);
        run_line("R7 pair", 1'b0, 1'b0, 1'b0, 8'hFF, 2, 8'h7F);
    endtask

    task automatic t_err();
        step("R5 err", 1'b1, 1'b0, 8'h00, 1'b1, 1'b1, 8'hFF);
        step("R5 err", 1'b1, 1'b0, 8'h00, 1'b1, 1'b1, 8'hFF);
        check("R5 err set", {7'd0, mode_err_o}, 8'h01);
        step("R5 err", 1'b1, 1'b0, 8'h00, 1'b1, 1'b0, 8'hFF);
        step("R5 err", 1'b1, 1'b0, 8'h00, 1'b1, 1'b0, 8'hFF);
        check("R5 err clear", {7'd0, mode_err_o}, 8'h00);
    endtask

    initial begin
        #(200000 * 4);
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_full_pass();
        t_nibble_low();
        t_nibble_high();
        t_mask();
        t_ignore();
        t_short_lines();
        t_err();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule